// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block watches a parallel, asynchronous static-memory bus and looks for a fixed unlock pattern made of six read accesses. The first five reads must hit a fixed chain of addresses. The sixth read picks the command: one final address asks for a nonvolatile store, another asks for a recall. When a command is recognised, the block raises a one-cycle request pulse for the executor and then holds `busy` so that normal memory access stays disabled. It stays that way until the executor reports completion on `op_done`.

The bus pins are asynchronous to `clk`. The block brings them in through a synchronizer chain of `SYNC_STAGES` flops. One access is counted per chip-enable strobe, and it is judged when the strobe is released. The address used is the one last seen while the strobe was active. The access counts as a write if write enable was low in any cycle of the strobe. Output enable plays no part in acceptance, so it is not an input of the block.

Between the strobe unit and the matcher, accesses travel as a valid-only event. The matcher accepts an event in every cycle, so that path has no back-pressure. The request pulses and `busy` are plain control outputs.

Top module: `seq_cmd_detect`

## Requirements
- R1: After reset, `step_count` is 0, `busy` is 0, and neither request pulse is asserted.
- R2: Step k (k = 0..4) accepts only a read of this table entry: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, with index k. Each accepted read raises `step_count` by one, up to 5.
- R3: With `step_count` at 5, a read of 0x0F0F asserts `store_req` for exactly one cycle, sets `busy` and returns `step_count` to 0.
- R4: With `step_count` at 5, a read of 0x0F0E asserts `recall_req` for exactly one cycle, sets `busy` and returns `step_count` to 0.
- R5: A write access at any step returns `step_count` to 0 and issues no command. A strobe counts as a write if write enable is low in any cycle of the strobe.
- R6: A read of an unexpected address returns `step_count` to 0 and issues no command. The one exception is a read of 0x0000, which leaves `step_count` at 1.
- R7: One chip-enable strobe counts as at most one step, however long it is held.
- R8: While `busy` is 1, reads and writes leave `step_count` at 0 and raise no request. `op_done` clears `busy`. An access that is evaluated in the same cycle as the `op_done` that ends `busy` is ignored.
- R9: `op_done` has no effect when `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (13) | Asynchronous bus address |
| bus_ce_n | input | 1 | Chip-enable strobe, active low |
| bus_we_n | input | 1 | Write enable, active low |
| op_done | input | 1 | Executor reports that the store or recall is finished |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |
| busy | output | 1 | Command executing; normal access disabled |
| step_count | output | 3 | Number of sequence steps accepted so far (0..5) |

## Verification
Two things can land on the same clock edge: completion of a running command (`op_done`) and evaluation of a bus access that was released while the block was busy. The bench provokes this by releasing a 0x0000 strobe during `busy` and raising `op_done` exactly in the cycle the synchronized release reaches the matcher. That cycle is two edges after the release. The expected result is that `busy` drops and `step_count` stays at 0: the access is judged against the busy state and must not be taken as a fresh first step.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int NUM_STEPS  = 6;
  localparam int PREFIX_LEN = NUM_STEPS - 1;

  localparam logic [15:0] KEY_STORE  = 16'h0F0F;
  localparam logic [15:0] KEY_RECALL = 16'h0F0E;

  typedef enum logic [0:0] {
    MODE_ARMED = 1'b0,
    MODE_BUSY  = 1'b1
  } seq_mode_e;

  // Unlock prefix; the order is the protocol itself.
  function automatic logic [15:0] prefix_key(input int idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'h1555;
      2:       return 16'h0AAA;
      3:       return 16'h1FFF;
      default: return 16'h10F0;
    endcase
  endfunction

endpackage

// File: rtl/seqdet_sync.sv
module seqdet_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {W{RST_BIT}};
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{{W{RST_BIT}}}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/seqdet_strobe.sv
module seqdet_strobe #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              ev_valid,
  output logic              ev_write,
  output logic [ADDR_W-1:0] ev_addr
);

  logic              ce_n_q;
  logic              wr_acc;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      wr_acc <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_n_q <= ce_n_s;
      if (!ce_n_s) begin
        addr_q <= addr_s;
        wr_acc <= wr_acc | ~we_n_s;
      end else begin
        wr_acc <= 1'b0;
      end
    end
  end

  // The event fires on the release of the strobe.
  assign ev_valid = ce_n_s & ~ce_n_q;
  assign ev_write = wr_acc;
  assign ev_addr  = addr_q;

endmodule

// File: rtl/seqdet_matcher.sv
module seqdet_matcher
  import seqdet_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_write,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              op_done,
  output logic              store_req,
  output logic              recall_req,
  output logic              busy,
  output logic [CNT_W-1:0]  step_count
);

  localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(PREFIX_LEN);
  localparam logic [ADDR_W-1:0] A_FIRST   = ADDR_W'(prefix_key(0));
  localparam logic [ADDR_W-1:0] A_STORE   = ADDR_W'(KEY_STORE);
  localparam logic [ADDR_W-1:0] A_RECALL  = ADDR_W'(KEY_RECALL);

  seq_mode_e         mode, mode_nx;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              st_nx, rc_nx;
  logic [ADDR_W-1:0] want;
  logic [CNT_W-1:0]  restart;

  assign want    = ADDR_W'(prefix_key(int'(cnt)));
  assign restart = (ev_addr == A_FIRST) ? CNT_W'(1) : '0;

  always_comb begin
    mode_nx = mode;
    cnt_nx  = cnt;
    st_nx   = 1'b0;
    rc_nx   = 1'b0;
    case (mode)
      MODE_BUSY: begin
        cnt_nx = '0;
        if (op_done) mode_nx = MODE_ARMED;
      end
      default: begin
        if (ev_valid) begin
          if (ev_write) begin
            cnt_nx = '0;
          end else if (cnt == LAST_STEP) begin
            if (ev_addr == A_STORE) begin
              st_nx   = 1'b1;
              mode_nx = MODE_BUSY;
              cnt_nx  = '0;
            end else if (ev_addr == A_RECALL) begin
              rc_nx   = 1'b1;
              mode_nx = MODE_BUSY;
              cnt_nx  = '0;
            end else begin
              cnt_nx = restart;
            end
          end else if (ev_addr == want) begin
            cnt_nx = cnt + CNT_W'(1);
          end else begin
            cnt_nx = restart;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_ARMED;
      cnt        <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      mode       <= mode_nx;
      cnt        <= cnt_nx;
      store_req  <= st_nx;
      recall_req <= rc_nx;
    end
  end

  assign busy       = (mode == MODE_BUSY);
  assign step_count = cnt;

endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
  import seqdet_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              op_done,
  output logic              store_req,
  output logic              recall_req,
  output logic              busy,
  output logic [$clog2(NUM_STEPS)-1:0] step_count
);

  localparam int CNT_W = $clog2(NUM_STEPS);

  logic [1:0]        ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic              ev_valid, ev_write;
  logic [ADDR_W-1:0] ev_addr;

  seqdet_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_ce_n, bus_we_n}), .q(ctl_s)
  );

  seqdet_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_addr_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_addr), .q(addr_s)
  );

  seqdet_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .ce_n_s(ctl_s[1]), .we_n_s(ctl_s[0]), .addr_s(addr_s),
    .ev_valid(ev_valid), .ev_write(ev_write), .ev_addr(ev_addr)
  );

  seqdet_matcher #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_write(ev_write), .ev_addr(ev_addr),
    .op_done(op_done),
    .store_req(store_req), .recall_req(recall_req),
    .busy(busy), .step_count(step_count)
  );

endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             store_req,
  input logic             recall_req,
  input logic             busy,
  input logic             op_done,
  input logic [CNT_W-1:0] step_count
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_count <= CNT_W'(5));

  assert_store_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  assert_store_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> (busy && step_count == '0));

  assert_recall_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);

  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));

  assert_busy_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (store_req || recall_req));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step_count == '0 && !store_req && !recall_req));

  assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);

endmodule

bind seq_cmd_detect seqdet_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .store_req(store_req), .recall_req(recall_req),
  .busy(busy), .op_done(op_done), .step_count(step_count)
);

// File: tb/seq_cmd_detect_bench.sv
`timescale 1ns/1ps
module seq_cmd_detect_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_ce_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic        op_done = 1'b0;
  logic        store_req, recall_req, busy;
  logic [2:0]  step_count;

  int checks = 0;
  int errors = 0;
  int n_store = 0;
  int n_recall = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seq_cmd_detect u_seq_cmd_detect (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ce_n(bus_ce_n),
    .bus_we_n(bus_we_n), .op_done(op_done), .store_req(store_req),
    .recall_req(recall_req), .busy(busy), .step_count(step_count)
  );

  always @(posedge clk) begin
    if (store_req)  n_store++;
    if (recall_req) n_recall++;
  end

  function automatic logic [12:0] key(input int i);
    logic [12:0] t [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    return t[i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [12:0] a, input bit wr, input int hold);
    @(negedge clk);
    bus_addr = a; bus_we_n = ~wr; bus_ce_n = 1'b0;
    repeat (hold) @(negedge clk);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic prefix(input int k);
    for (int i = 0; i < k; i++) access(key(i), 1'b0, 2);
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 step", step_count, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req", store_req | recall_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep over every step position: advance, write abort, bad read, restart
    for (int k = 0; k < 6; k++) begin
      access(13'h0001, 1'b1, 2);
      prefix(k);
      chk("R2 advance", step_count, k);
      access(key(k % 5), 1'b1, 2);
      chk("R5 write abort", step_count, 0);
      prefix(k);
      access(13'h1234, 1'b0, 2);
      chk("R6 bad read", step_count, 0);
      prefix(k);
      access(13'h0000, 1'b0, 2);
      chk("R6 restart", step_count, (k == 0) ? 1 : 1);
    end
    // Wrong final addresses near the command keys
    for (int j = 0; j < 4; j++) begin
      logic [12:0] bad;
      bad = (j == 0) ? 13'h0F0D : (j == 1) ? 13'h0F1F : (j == 2) ? 13'h1F0F : 13'h0F0C;
      access(13'h0001, 1'b1, 2);
      prefix(5);
      access(bad, 1'b0, 2);
      chk("R6 bad final", step_count, 0);
    end
    chk("R6 no store", n_store, 0);
    chk("R6 no recall", n_recall, 0);

    // R7: long strobes count once each
    access(13'h0000, 1'b0, 14);
    chk("R7 long strobe", step_count, 1);
    access(13'h1555, 1'b0, 14);
    chk("R7 second long strobe", step_count, 2);
    // R5: write enable low for one cycle inside the strobe
    @(negedge clk); bus_addr = 13'h0AAA; bus_ce_n = 1'b0;
    repeat (3) @(negedge clk); bus_we_n = 1'b0;
    @(negedge clk); bus_we_n = 1'b1;
    repeat (3) @(negedge clk); bus_ce_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 mid-strobe write", step_count, 0);

    // R3 store
    prefix(5);
    access(13'h0F0F, 1'b0, 2);
    chk("R3 store pulses", n_store, 1);
    chk("R3 busy", busy, 1);
    chk("R3 step cleared", step_count, 0);
    chk("R3 no recall", n_recall, 0);

    // R8 accesses during busy ignored
    access(13'h0000, 1'b0, 2);
    chk("R8 read while busy", step_count, 0);
    prefix(5);
    access(13'h0F0F, 1'b0, 2);
    chk("R8 no new store", n_store, 1);
    chk("R8 still busy", busy, 1);
    pulse_done();
    chk("R8 done clears busy", busy, 0);

    // R9 op_done when idle
    prefix(2);
    pulse_done();
    chk("R9 step kept", step_count, 2);
    chk("R9 busy stays low", busy, 0);

    // R4 recall
    for (int i = 2; i < 5; i++) access(key(i), 1'b0, 2);
    access(13'h0F0E, 1'b0, 2);
    chk("R4 recall pulses", n_recall, 1);
    chk("R4 busy", busy, 1);
    chk("R4 no store", n_store, 1);

    // R8 coincidence: access reaches matcher on the same edge as op_done
    @(negedge clk); bus_addr = 13'h0000; bus_ce_n = 1'b0;
    repeat (3) @(negedge clk); bus_ce_n = 1'b1;
    @(negedge clk);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 coincident busy", busy, 0);
    chk("R8 coincident step", step_count, 0);
    access(13'h0000, 1'b0, 2);
    chk("R8 armed after done", step_count, 1);

    finish_run();
  end

endmodule